// File: doc/BRIEF.md
# Iterative Unsigned Multiplier and Divider

This block performs an unsigned 8 by 8 multiplication or an unsigned 8 by 8 division over several cycles, working on two byte operands taken from a pair of processor registers. The caller asserts `go` for one cycle with an operation select and the two operands. The block copies the operands into its own registers and then computes one bit per cycle. Multiplication uses shift-and-add. Division uses restoring shift-and-subtract.

When the operation ends, `fin` pulses high for one cycle. The two result bytes and the carry bit then hold their values until the next accepted start. Multiplication writes the high byte of the 16-bit product to the first result (`res_a`) and the low byte to the second (`res_b`). Division writes the quotient to `res_a` and the remainder to `res_b`. A zero divisor is caught at start and gives a fixed result in a single cycle, with carry raised.

Top module: `seq_muldiv`

## Requirements
- R1: After reset, `busy` and `fin` are 0 and `res_a`, `res_b` and `cy` are 0.
- R2: With `op`=0 (multiply), `{res_a,res_b}` equals the unsigned product `a*b`, with the high byte in `res_a`, and `cy` is 0.
- R3: With `op`=1 (divide) and `b`≠0, `res_a` equals `a/b` and `res_b` equals `a%b`, both unsigned, and `cy` is 0.
- R4: With `op`=1 and `b`=0, the result is `res_a`=0xFF, `res_b`=0x00 and `cy`=1.
- R5: A zero-divisor divide raises `fin` one cycle after the start edge and never raises `busy`. Every other operation holds `busy` high for exactly 8 cycles, and `fin` rises in the cycle after `busy` falls.
- R6: `fin` is high for one cycle only, and only when an operation ends.
- R7: A `go` pulse while `busy` is high is ignored. The running operation completes with its original operands and op, and no extra `fin` follows.
- R8: The operands and op are captured when `go` is accepted, so changing `a`, `b` or `op` during the computation does not affect the result.
- R9: `res_a`, `res_b` and `cy` do not change between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start request, taken when not busy |
| op | input | 1 | 0 = multiply, 1 = divide |
| a | input | 8 | First operand (dividend / multiplicand) |
| b | input | 8 | Second operand (divisor / multiplier) |
| busy | output | 1 | Iteration in progress |
| fin | output | 1 | One-cycle completion pulse |
| res_a | output | 8 | Product high byte or quotient |
| res_b | output | 8 | Product low byte or remainder |
| cy | output | 1 | Carry: set only on divide by zero |

## Verification
The bench targets the extreme operands: 255×255, which a design that loses the last carry from the adder drops to a wrong high byte, and 255÷1 and 0÷x. It also targets divisors larger than the dividend, where a restoring step that mis-sizes the partial remainder produces a wrong quotient. Division by zero is checked for its fixed pattern and its one-cycle latency; a design that iterates anyway returns garbage late. A start during busy and operands that change mid-run expose a design that restarts or reads live inputs, since either gives a different result or an extra completion pulse.

// File: rtl/seq_muldiv.sv
module seq_muldiv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] res_a,
  output logic [W-1:0] res_b,
  output logic         cy
);
  localparam int CW = $clog2(W + 1);

  logic         op_q;
  logic [W-1:0] acc;
  logic [W-1:0] lo;
  logic [W-1:0] opd;
  logic [CW-1:0] cnt;
  logic         finish;

  wire          accept = go && !busy;
  wire [W:0]    sum    = {1'b0, acc} + (lo[0] ? {1'b0, opd} : '0);
  wire [W:0]    shrem  = {acc, lo[W-1]};
  wire [W:0]    diff   = shrem - {1'b0, opd};
  wire          fits   = !diff[W];

  assign finish = busy && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      fin   <= 1'b0;
      op_q  <= 1'b0;
      acc   <= '0;
      lo    <= '0;
      opd   <= '0;
      cnt   <= '0;
      res_a <= '0;
      res_b <= '0;
      cy    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (accept) begin
        if (op && b == '0) begin
          res_a <= '1;
          res_b <= '0;
          cy    <= 1'b1;
          fin   <= 1'b1;
        end else begin
          busy <= 1'b1;
          op_q <= op;
          acc  <= '0;
          lo   <= op ? a : b;
          opd  <= op ? b : a;
          cnt  <= CW'(W);
        end
      end else if (busy) begin
        cnt <= cnt - 1'b1;
        if (!op_q) begin
          acc <= sum[W:1];
          lo  <= {sum[0], lo[W-1:1]};
        end else begin
          acc <= fits ? diff[W-1:0] : shrem[W-1:0];
          lo  <= {lo[W-2:0], fits};
        end
        if (finish) begin
          busy <= 1'b0;
          fin  <= 1'b1;
          cy   <= 1'b0;
          if (!op_q) begin
            res_a <= sum[W:1];
            res_b <= {sum[0], lo[W-1:1]};
          end else begin
            res_a <= {lo[W-2:0], fits};
            res_b <= fits ? diff[W-1:0] : shrem[W-1:0];
          end
        end
      end
    end
  end
endmodule

module seq_muldiv_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         go,
  input logic         busy,
  input logic         fin,
  input logic [W-1:0] res_a,
  input logic [W-1:0] res_b,
  input logic         cy
);
  logic [4:0] run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else if (busy) run <= run + 1'b1;
    else run <= '0;

  AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n) fin |=> !fin); // R6
  AST_FIN_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) fin |-> !busy); // R5
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n) busy |-> run < 5'(W)); // R5
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> fin); // R5
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !fin |-> $stable(res_a) && $stable(res_b) && $stable(cy)); // R9
  AST_CY_PATTERN: assert property (@(posedge clk) disable iff (!rst_n) (fin && cy) |-> res_a == '1 && res_b == '0); // R4
  AST_IGNORE_GO: assert property (@(posedge clk) disable iff (!rst_n) (busy && run < 5'(W-1)) |=> busy); // R7
endmodule

bind seq_muldiv seq_muldiv_chk #(.W(W)) u_chk (.*);

// File: tb/sim_seq_muldiv.sv
module sim_seq_muldiv;
  logic clk = 0, rst_n = 0, go = 0, op = 0;
  logic [7:0] a = 0, b = 0;
  logic busy, fin, cy;
  logic [7:0] res_a, res_b;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  seq_muldiv u0 (.*);

  localparam int N = 12;
  localparam logic [16:0] VEC [N] = '{
    {1'b0, 8'd255, 8'd255}, {1'b0, 8'd0, 8'd200}, {1'b0, 8'd13, 8'd11},
    {1'b0, 8'd128, 8'd2}, {1'b0, 8'd1, 8'd255}, {1'b1, 8'd255, 8'd1},
    {1'b1, 8'd0, 8'd7}, {1'b1, 8'd5, 8'd200}, {1'b1, 8'd200, 8'd7},
    {1'b1, 8'd255, 8'd255}, {1'b1, 8'd100, 8'd0}, {1'b1, 8'd128, 8'd3}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run_op(input logic o, input logic [7:0] x, input logic [7:0] y,
                        input bit disturb, output int lat, output int fins);
    @(negedge clk); go = 1; op = o; a = x; b = y;
    @(negedge clk); go = 0;
    lat = 1; fins = 0;
    if (fin) fins++;
    while (!fin && lat < 40) begin
      if (disturb && lat == 3) begin go = 1; op = ~o; a = ~x; b = 8'd1; end
      if (disturb && lat == 4) go = 0;
      @(negedge clk); lat++;
      if (fin) fins++;
    end
    go = 0;
    repeat (3) begin @(negedge clk); if (fin) fins++; end
  endtask

  task automatic expect_res(input string rq, input logic o, input logic [7:0] x, input logic [7:0] y);
    logic [15:0] p;
    if (!o) begin
      p = x * y;
      chk(rq, {res_a, res_b, 7'd0, cy}, {p, 8'd0});
    end else if (y == 0) begin
      chk("R4", {res_a, res_b, 7'd0, cy}, {8'hFF, 8'h00, 8'd1});
    end else begin
      chk(rq, {res_a, res_b, 7'd0, cy}, {x / y, x % y, 8'd0});
    end
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat, fins;
    logic [7:0] ra;
    repeat (3) @(negedge clk);
    chk("R1", {busy, fin, res_a, res_b, cy}, 19'd0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      run_op(VEC[i][16], VEC[i][15:8], VEC[i][7:0], 0, lat, fins);
      expect_res(VEC[i][16] ? "R3" : "R2", VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
      chk("R6", fins, 1);
    end
    run_op(1, 8'd9, 8'd0, 0, lat, fins);
    chk("R5", lat, 1);
    chk("R4", {res_a, res_b, 7'd0, cy}, {8'hFF, 8'h00, 8'd1});
    run_op(0, 8'd3, 8'd4, 0, lat, fins);
    chk("R5", lat, 9);
    chk("R2", {res_a, res_b, 7'd0, cy}, {16'd12, 8'd0});
    run_op(1, 8'd250, 8'd9, 1, lat, fins);
    chk("R7", fins, 1);
    chk("R8", {res_a, res_b}, {8'd27, 8'd7});
    ra = res_a;
    repeat (5) @(negedge clk);
    chk("R9", res_a, ra);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule